// File: doc/BRIEF.md
# Bit-Serial 5x5 Convolution Processing Element

This block is one column-level processing element of a SIMD image-filter array. It owns a strip of five adjacent output columns and applies a 5x5 kernel of signed, programmable coefficients to an image that arrives one row per transaction. Each row word carries nine pixels: the element's own five columns plus two halo columns on each side. The last five rows stay in a window register inside the block, so the output for a row is the filtered pixel of the row two positions older, centred in the window.

The kernel sum is formed bit-serially. In each cycle the element takes one bit-plane of one window row, adds the coefficients whose pixel bit is set, shifts that partial sum by the bit index, and accumulates it. Coefficients come one kernel row at a time from a coefficient store shared by all elements: the element drives a row address and reads five coefficients back in the same cycle. Gray mode walks eight bit-planes (40 cycles per row). Binary mode uses only the least significant bit (5 cycles per row). Gray results are clamped to 0..255. Binary results are compared against a signed threshold.

Top module: `conv5_pe`

## Requirements
- R1: After reset, `done` is low, `pixOut` is all zero and `coefAddr` is 0.
- R2: On completion, output column j (0..4, at `pixOut[j*8 +: 8]`) equals the sum over kernel row r and kernel column c (0..4 each) of coef(r,c) times the pixel at window row r and input column j+c. Window row 4 is the row just accepted and row 0 is the oldest. Input column i is `rowPix[i*8 +: 8]`. coef(r,c) is the signed 8-bit value at `coefRowData[c*8 +: 8]` while `coefAddr` = r.
- R3: In gray mode (`binMode`=0) a sum below 0 gives 0 and a sum above 255 gives 255.
- R4: In binary mode (`binMode`=1) only bit 0 of each pixel enters the sum, and output column j is 1 in its bit 0 when the sum is at least the signed value of `thresh`, else 0. Its other seven bits are 0.
- R5: `done` is high for exactly one cycle, starting 40 clock edges (gray) or 5 clock edges (binary) after the edge that accepted `start`. `pixOut` holds its value until the next `done`.
- R6: While a row is processed, `coefAddr` steps 0,1,2,3,4 and repeats this sequence once per bit-plane.
- R7: `newFrame`=1 with an accepted `start` turns the four older window rows to zero, so rows of a previous frame do not reach the output.
- R8: With `leftEdge`=1 input columns 0 and 1 are taken as zero. With `rightEdge`=1 input columns 7 and 8 are taken as zero. With `blankRow`=1 the whole accepted row is taken as zero.
- R9: `start` while a row is in progress is ignored: the row data, flags and timing of that row are unchanged, and the window does not shift.
- R10: `binMode` and `thresh` are sampled when `start` is accepted. Changes during processing do not affect that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a new row when idle |
| newFrame | input | 1 | Clear older window rows with this row |
| binMode | input | 1 | 1 = binary mode, 0 = 8-bit gray mode |
| leftEdge | input | 1 | Left halo columns lie outside the image |
| rightEdge | input | 1 | Right halo columns lie outside the image |
| blankRow | input | 1 | Treat the accepted row as all zero |
| rowPix | input | 72 | Nine 8-bit pixels, column i at bits i*8+7..i*8 |
| thresh | input | 21 | Signed binary-mode threshold |
| coefAddr | output | 3 | Kernel row address to the shared coefficient store |
| coefRowData | input | 40 | Five signed 8-bit coefficients of the addressed row |
| pixOut | output | 40 | Five filtered output pixels |
| done | output | 1 | One-cycle pulse when pixOut is updated |

## Verification
The bench uses signed kernels with negative entries and large weights, so the results fall below zero and above 255. A design that kept only the low byte instead of clamping, or that shifted the partial sums without sign extension, would give wrong pixels there. Binary rows carry set upper bits, so a design that read more than bit 0, or that ran eight bit-planes instead of one, would show a wrong value or a wrong latency. A second `start` during a row comes with a different row, flags and mode, and a design that restarted or sampled those late would finish early or shift its window. The tests also cover frame restarts, edge halos and blank rows, which catch a design that kept stale rows or ignored the zeroing.

// File: rtl/conv5_pkg.sv
package conv5_pkg;
  localparam int PIX_W     = 8;                       // gray pixel width
  localparam int COEF_W    = 8;                       // signed coefficient width
  localparam int KDIM      = 5;                       // kernel edge length
  localparam int OUT_COLS  = 5;                       // columns owned per element
  localparam int HALO      = KDIM / 2;
  localparam int SPAN      = OUT_COLS + KDIM - 1;     // pixels per row word
  localparam int ACC_W     = PIX_W + COEF_W + $clog2(KDIM * KDIM);
  localparam int PART_W    = COEF_W + $clog2(KDIM);   // one kernel row, one bit-plane
  localparam int BIT_IDX_W = $clog2(PIX_W);
  localparam int ROW_IDX_W = $clog2(KDIM);

  typedef struct packed {
    logic                 load;     // row accepted this cycle
    logic                 step;     // accumulate one (row, bit-plane)
    logic                 last;     // final step of the row
    logic                 binMode;  // mode latched at acceptance
    logic [BIT_IDX_W-1:0] bitIdx;
    logic [ROW_IDX_W-1:0] rowIdx;
  } strobe_t;
endpackage

// File: rtl/conv5_ctrl.sv
module conv5_ctrl
  import conv5_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    binMode,
  output strobe_t stb,
  output logic    busy
);
  logic [BIT_IDX_W-1:0] bitCnt;
  logic [ROW_IDX_W-1:0] rowCnt;
  logic                 binQ;
  logic [BIT_IDX_W-1:0] lastBit;
  logic                 accept;
  logic                 rowWrap;

  assign accept  = start && !busy;
  assign lastBit = binQ ? '0 : BIT_IDX_W'(PIX_W - 1);
  assign rowWrap = (rowCnt == ROW_IDX_W'(KDIM - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      binQ   <= 1'b0;
      bitCnt <= '0;
      rowCnt <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      binQ   <= binMode;
      bitCnt <= '0;
      rowCnt <= '0;
    end else if (busy) begin
      if (rowWrap) begin
        rowCnt <= '0;
        if (bitCnt == lastBit) busy <= 1'b0;
        else bitCnt <= bitCnt + 1'b1;
      end else begin
        rowCnt <= rowCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb.load    = accept;
    stb.step    = busy;
    stb.last    = busy && rowWrap && (bitCnt == lastBit);
    stb.binMode = binQ;
    stb.bitIdx  = bitCnt;
    stb.rowIdx  = rowCnt;
  end
endmodule

// File: rtl/conv5_dp.sv
module conv5_dp
  import conv5_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    stb,
  input  logic [SPAN*PIX_W-1:0]      rowPix,
  input  logic                       newFrame,
  input  logic                       leftEdge,
  input  logic                       rightEdge,
  input  logic                       blankRow,
  input  logic signed [ACC_W-1:0]    thresh,
  input  logic [KDIM*COEF_W-1:0]     coefRowData,
  output logic [OUT_COLS*PIX_W-1:0]  pixOut,
  output logic                       done
);
  localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'((1 << PIX_W) - 1);

  logic [PIX_W-1:0]         win   [KDIM][SPAN];
  logic [PIX_W-1:0]         inRow [SPAN];
  logic signed [ACC_W-1:0]  threshQ;

  // halo and blank masking of the incoming row
  always_comb begin
    for (int c = 0; c < SPAN; c++) begin
      inRow[c] = rowPix[c*PIX_W +: PIX_W];
      if (blankRow || (leftEdge && c < HALO) || (rightEdge && c >= SPAN - HALO))
        inRow[c] = '0;
    end
  end

  // five-row window: row KDIM-1 newest
  always_ff @(posedge clk) begin
    if (!rstN) begin
      threshQ <= '0;
      for (int r = 0; r < KDIM; r++)
        for (int c = 0; c < SPAN; c++) win[r][c] <= '0;
    end else if (stb.load) begin
      threshQ <= thresh;
      for (int c = 0; c < SPAN; c++) begin
        for (int r = 0; r < KDIM - 1; r++)
          win[r][c] <= newFrame ? '0 : win[r+1][c];
        win[KDIM-1][c] <= inRow[c];
      end
    end
  end

  for (genvar j = 0; j < OUT_COLS; j++) begin : g_col
    logic signed [PART_W-1:0] partSum;
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  nextAcc;
    logic [PIX_W-1:0]         outPix;
    logic [PIX_W-1:0]         pixQ;

    always_comb begin
      partSum = '0;
      for (int kc = 0; kc < KDIM; kc++)
        if (win[stb.rowIdx][j+kc][stb.bitIdx])
          partSum = partSum + PART_W'($signed(coefRowData[kc*COEF_W +: COEF_W]));
    end

    assign nextAcc = acc + (ACC_W'(partSum) <<< stb.bitIdx);

    always_comb begin
      if (stb.binMode)     outPix = {{(PIX_W-1){1'b0}}, (nextAcc >= threshQ)};
      else if (nextAcc < 0)       outPix = '0;
      else if (nextAcc > PIX_MAX) outPix = '1;
      else                        outPix = nextAcc[PIX_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        acc  <= '0;
        pixQ <= '0;
      end else begin
        if (stb.load)      acc <= '0;
        else if (stb.step) acc <= nextAcc;
        if (stb.last)      pixQ <= outPix;
      end
    end

    assign pixOut[j*PIX_W +: PIX_W] = pixQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) done <= 1'b0;
    else       done <= stb.last;
  end
endmodule

// File: rtl/conv5_pe.sv
module conv5_pe
  import conv5_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic                       newFrame,
  input  logic                       binMode,
  input  logic                       leftEdge,
  input  logic                       rightEdge,
  input  logic                       blankRow,
  input  logic [SPAN*PIX_W-1:0]      rowPix,
  input  logic signed [ACC_W-1:0]    thresh,
  output logic [ROW_IDX_W-1:0]       coefAddr,
  input  logic [KDIM*COEF_W-1:0]     coefRowData,
  output logic [OUT_COLS*PIX_W-1:0]  pixOut,
  output logic                       done
);
  strobe_t stb;
  logic    busy;

  conv5_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .binMode(binMode),
    .stb(stb), .busy(busy)
  );

  conv5_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rowPix(rowPix),
    .newFrame(newFrame), .leftEdge(leftEdge), .rightEdge(rightEdge),
    .blankRow(blankRow), .thresh(thresh), .coefRowData(coefRowData),
    .pixOut(pixOut), .done(done)
  );

  assign coefAddr = stb.rowIdx;
endmodule

// File: rtl/conv5_chk.sv
module conv5_chk
  import conv5_pkg::*;
(
  input logic                      clk,
  input logic                      rstN,
  input logic                      start,
  input logic                      done,
  input logic [ROW_IDX_W-1:0]      coefAddr,
  input logic [OUT_COLS*PIX_W-1:0] pixOut,
  input strobe_t                   stb,
  input logic                      busy
);
  logic [7:0] stepCnt;

  always_ff @(posedge clk) begin
    if (!rstN)         stepCnt <= '0;
    else if (stb.load) stepCnt <= '0;
    else if (stb.step) stepCnt <= stepCnt + 1'b1;
  end

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (stepCnt == (stb.binMode ? 8'(KDIM) : 8'(KDIM * PIX_W))));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(pixOut));

  p_addr_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    coefAddr < ROW_IDX_W'(KDIM));

  p_addr_seq_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && !stb.last) |=>
      (coefAddr == (($past(coefAddr) == ROW_IDX_W'(KDIM - 1)) ? '0 : $past(coefAddr) + 1'b1)));

  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && !stb.last && start) |=> (stb.step && !stb.load));

  for (genvar j = 0; j < OUT_COLS; j++) begin : g_bin
    p_binary_bits_r4: assert property (@(posedge clk) disable iff (!rstN)
      (done && stb.binMode) |-> (pixOut[j*PIX_W+1 +: PIX_W-1] == '0));
  end
endmodule

bind conv5_pe conv5_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .done(done), .coefAddr(coefAddr),
  .pixOut(pixOut), .stb(stb), .busy(busy)
);

// File: tb/conv5_pe_tb.sv
`timescale 1ns/1ps
module conv5_pe_tb;
  typedef int row_t [9];

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, newFrame = 1'b0, binMode = 1'b0;
  logic        leftEdge = 1'b0, rightEdge = 1'b0, blankRow = 1'b0;
  logic [71:0] rowPix = '0;
  logic [20:0] thresh = '0;
  logic [2:0]  coefAddr;
  logic [39:0] coefRowData;
  logic [39:0] pixOut;
  logic        done;

  int checks = 0, errors = 0;
  int kern [5][5];
  int hist [5][9];

  always #2.5 clk = ~clk;

  conv5_pe u_dut (
    .clk(clk), .rstN(rstN), .start(start), .newFrame(newFrame), .binMode(binMode),
    .leftEdge(leftEdge), .rightEdge(rightEdge), .blankRow(blankRow), .rowPix(rowPix),
    .thresh(thresh), .coefAddr(coefAddr), .coefRowData(coefRowData),
    .pixOut(pixOut), .done(done)
  );

  // shared coefficient store model: combinational read
  always_comb begin
    coefRowData = '0;
    for (int c = 0; c < 5; c++)
      if (coefAddr < 3'd5) coefRowData[c*8 +: 8] = 8'(kern[coefAddr][c]);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic row_t mkRow(input int seed);
    row_t r;
    for (int c = 0; c < 9; c++) r[c] = (seed * 53 + c * 29 + seed * c * 7) % 256;
    return r;
  endfunction

  function automatic row_t flatRow(input int v);
    row_t r;
    for (int c = 0; c < 9; c++) r[c] = v;
    return r;
  endfunction

  // one row through the block; extraAt > 0 fires an extra start while busy
  task automatic sendRow(input row_t px, input bit nf, input bit le, input bit re,
                         input bit bl, input bit bm, input int th, input int extraAt,
                         input string tag);
    int expv [5];
    int lat, cnt, sum;
    bit addrOk;
    logic [39:0] held;
    lat = bm ? 5 : 40;
    // reference window
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 9; c++) hist[r][c] = nf ? 0 : hist[r+1][c];
    for (int c = 0; c < 9; c++)
      hist[4][c] = (bl || (le && c < 2) || (re && c > 6)) ? 0 : px[c];
    for (int j = 0; j < 5; j++) begin
      sum = 0;
      for (int r = 0; r < 5; r++)
        for (int c = 0; c < 5; c++)
          sum += kern[r][c] * (bm ? (hist[r][j+c] & 1) : hist[r][j+c]);
      if (bm) expv[j] = (sum >= th) ? 1 : 0;
      else    expv[j] = (sum < 0) ? 0 : ((sum > 255) ? 255 : sum);
    end
    for (int c = 0; c < 9; c++) rowPix[c*8 +: 8] = 8'(px[c]);
    newFrame = nf; leftEdge = le; rightEdge = re; blankRow = bl;
    binMode = bm; thresh = 21'(th); start = 1'b1;
    cnt = 0; addrOk = 1'b1;
    while (!done && cnt < 100) begin
      @(negedge clk);
      cnt++;
      start = 1'b0;
      if (cnt == extraAt) begin  // R9 R10: late start with different everything
        start = 1'b1; rowPix = {9{8'hA5}}; newFrame = 1'b1; blankRow = 1'b1;
        binMode = ~bm; thresh = 21'(th + 1000);
      end
      if (cnt <= lat && !done && coefAddr != 3'((cnt - 1) % 5)) addrOk = 1'b0;
    end
    start = 1'b0;
    check(addrOk, {tag, " R6 coefAddr sequence"}, int'(addrOk), 1);
    check(cnt == lat + 1, {tag, " R5 done latency"}, cnt, lat + 1);
    for (int j = 0; j < 5; j++)
      check(pixOut[j*8 +: 8] == 8'(expv[j]), tag, int'(pixOut[j*8 +: 8]), expv[j]);
    held = pixOut;
    rowPix = '1; thresh = '0; binMode = ~bm;
    @(negedge clk);
    check(!done, {tag, " R5 done one cycle"}, int'(done), 0);
    check(pixOut == held, {tag, " R5 output holds"}, int'(pixOut[7:0]), int'(held[7:0]));
  endtask

  task automatic t_reset;
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(pixOut == '0, "R1 pixOut after reset", int'(pixOut[7:0]), 0);
    check(coefAddr == '0, "R1 coefAddr after reset", int'(coefAddr), 0);
  endtask

  task automatic t_identity;  // R2: centre tap reproduces the pixel two rows back
    for (int r = 0; r < 5; r++) for (int c = 0; c < 5; c++) kern[r][c] = 0;
    kern[2][2] = 1;
    for (int i = 0; i < 6; i++)
      sendRow(mkRow(i + 1), i == 0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, "R2 identity");
  endtask

  task automatic t_signed;  // R2 R3: mixed signed kernel, clamp both ways
    for (int r = 0; r < 5; r++)
      for (int c = 0; c < 5; c++) kern[r][c] = ((r * 5 + c) * 37 % 17) - 8;
    kern[0][0] = -128; kern[4][4] = 127;
    for (int i = 0; i < 6; i++)
      sendRow(mkRow(i + 20), i == 0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, "R2 R3 signed");
    for (int r = 0; r < 5; r++) for (int c = 0; c < 5; c++) kern[r][c] = 1;
    for (int i = 0; i < 5; i++)
      sendRow(flatRow(200), i == 0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, "R3 clamp high");
    for (int r = 0; r < 5; r++) for (int c = 0; c < 5; c++) kern[r][c] = -1;
    kern[2][2] = 24;
    for (int i = 0; i < 5; i++)
      sendRow(i == 2 ? flatRow(0) : flatRow(90), i == 0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0,
              "R3 clamp low");
  endtask

  task automatic t_binary;  // R4: bit 0 only, signed threshold
    row_t px;
    for (int r = 0; r < 5; r++) for (int c = 0; c < 5; c++) kern[r][c] = 1;
    for (int i = 0; i < 6; i++) begin
      for (int c = 0; c < 9; c++) px[c] = ((i + c) % 3 == 0) ? 8'hFE : 8'hFF;
      sendRow(px, i == 0, 1'b0, 1'b0, 1'b0, 1'b1, 16, 0, "R4 binary");
    end
    kern[2][2] = -30;
    sendRow(flatRow(8'h81), 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, -6, 0, "R4 negative threshold");
  endtask

  task automatic t_border;  // R7 R8
    for (int r = 0; r < 5; r++)
      for (int c = 0; c < 5; c++) kern[r][c] = (r + c) % 2 == 0 ? 2 : 1;
    for (int i = 0; i < 3; i++)
      sendRow(mkRow(i + 40), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0, "R8 left edge");
    sendRow(mkRow(50), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, "R7 new frame");
    sendRow(mkRow(51), 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0, 0, "R8 right edge");
    sendRow(mkRow(52), 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 0, 0, "R8 blank row");
    sendRow(mkRow(53), 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 0, 0, "R8 both edges");
  endtask

  task automatic t_busy_start;  // R9 R10
    for (int r = 0; r < 5; r++)
      for (int c = 0; c < 5; c++) kern[r][c] = c - r;
    sendRow(mkRow(60), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, "R9 setup");
    sendRow(mkRow(61), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 10, "R9 R10 gray late start");
    sendRow(mkRow(62), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, "R9 window not shifted");
    sendRow(mkRow(63), 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2, 3, "R9 R10 binary late start");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < 5; r++) for (int c = 0; c < 9; c++) hist[r][c] = 0;
    for (int r = 0; r < 5; r++) for (int c = 0; c < 5; c++) kern[r][c] = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_identity();
    t_signed();
    t_binary();
    t_border();
    t_busy_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule